// File: doc/BRIEF.md
# Triggered Multichannel Waveform Capture Readout

This block records a fixed-length window of samples from eight 10-bit ADC channels and later hands them to a host over a shared bus. It sits idle until a start trigger arrives. It then writes one sample from every channel on each clock cycle, at 10 ns intervals with a 100 MHz clock, into a per-channel memory. Each sample is stored together with that channel's over-range flag. After 1024 samples per channel it raises a request toward the host. The host answers with an accept signal, and the block then sends the stored samples one word per accepted cycle. Each word carries the channel number, the sample index, the over-range flag and an even-parity bit.

The sequencer has four states. `ST_IDLE` waits for the trigger. `ST_CAPT` writes samples. `ST_REQ` holds the request. `ST_XFER` drives the bus. The transitions are named as follows. *arm* goes from IDLE to CAPT when the trigger is high. *full* goes from CAPT to REQ after the write of sample index 1023. *grant* goes from REQ to XFER when accept is high. *done* goes from XFER back to IDLE when the final word is accepted. In every other case the state holds. The output bus is driven only in `ST_XFER`, so several modules can share one host bus.

Top module: `wcap_readout`

## Requirements
- R1: After reset the block is idle. `host_req` and `bus_oe` are 0, and `host_bus` is not driven.
- R2: When `trig_in` is high at a clock edge in idle, the block stores the ADC inputs present at each of the next 1024 edges, with sample index 0 to 1023. Each sample is stored with its channel's `adc_ovr` bit.
- R3: `host_req` is 0 through the edge that writes sample 1022. It becomes 1 after the edge that writes sample 1023, with `bus_oe` still 0.
- R4: An edge with `host_ack` high while `host_req` is 1 clears `host_req`, sets `bus_oe`, and puts word 0 on `host_bus`.
- R5: Word layout: bit 24 is parity, bit 23 is the over-range flag, bits 22:20 are the channel, bits 19:10 are the 0-based sample index, and bits 9:0 are the sample.
- R6: Parity is even: the XOR of all 25 bits of each word is 0.
- R7: Words are sent in channel-major order (channel 0, samples 0..1023, then channel 1, and so on). The bus advances one word at each edge with `host_ack` high.
- R8: At an edge with `host_ack` low during transfer, the word on the bus is held unchanged and `bus_oe` stays 1.
- R9: The edge that accepts the last word (channel 7, sample 1023) returns the block to idle. `bus_oe` and `host_req` are then 0.
- R10: `trig_in` has no effect during capture, request or transfer. Capture timing, stored data and the word stream are unchanged.
- R11: A new trigger after a completed readout starts a fresh capture that overwrites all stored samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and logic clock (100 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Start trigger, sampled in idle |
| adc_data | input | 80 | Packed ADC samples, channel c at bits c*10+9:c*10 |
| adc_ovr | input | 8 | Per-channel over-range flag from the ADCs |
| host_req | output | 1 | Request to the host; data is ready |
| host_ack | input | 1 | Host accept; grants the transfer and advances words |
| bus_oe | output | 1 | High while the block drives `host_bus` |
| host_bus | inout | 25 | Shared three-state data bus |

## Verification
Assertions check the following on every cycle. Request and output enable are never high together. The request only rises after the write of the last sample index. The word address holds while accept is low. A trigger seen in the request or transfer state never restarts capture. Output enable only falls after the last word has been accepted. Every driven word has even parity. Only the bench scenarios can show that the stored values match what was on the ADC inputs at the right edges. They also show the exact edge on which the request rises, the full channel-major word stream under gaps in accept, and that a trigger injected mid-capture or a second capture leaves the correct data behind.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
    localparam int NCH_DEF   = 8;
    localparam int DW_DEF    = 10;
    localparam int DEPTH_DEF = 1024;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAPT = 2'd1,
        ST_REQ  = 2'd2,
        ST_XFER = 2'd3
    } wcap_state_e;
endpackage

// File: rtl/wcap_bank.sv
module wcap_bank #(
    parameter int DW    = 10,
    parameter int DEPTH = 1024,
    localparam int IX_W = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [IX_W-1:0] waddr,
    input  logic [DW:0]     wdata,
    input  logic [IX_W-1:0] raddr,
    output logic [DW:0]     rdata
);
    // one entry per sample: {over-range, data}
    logic [DW:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/wcap_pack.sv
module wcap_pack #(
    parameter int DW   = 10,
    parameter int CH_W = 3,
    parameter int IX_W = 10,
    localparam int WORD_W = 2 + CH_W + IX_W + DW
) (
    input  logic              ovr,
    input  logic [CH_W-1:0]   ch,
    input  logic [IX_W-1:0]   idx,
    input  logic [DW-1:0]     data,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-2:0] body;

    assign body = {ovr, ch, idx, data};
    // even parity: the parity bit makes the total count of ones even
    assign word = {^body, body};
endmodule

// File: rtl/wcap_seq.sv
module wcap_seq
    import wcap_pkg::*;
#(
    parameter int CH_W = 3,
    parameter int IX_W = 10,
    localparam int CNT_W = CH_W + IX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic             oe_o,
    output logic             wr_en_o,
    output logic [CNT_W-1:0] cnt_o
);
    wcap_state_e      st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             cap_last;
    logic             xfer_last;

    assign cap_last  = (cnt_q[IX_W-1:0] == {IX_W{1'b1}});
    assign xfer_last = (cnt_q == {CNT_W{1'b1}});

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (trig_i)             st_d = ST_CAPT;  // arm
            ST_CAPT: if (cap_last)           st_d = ST_REQ;   // full
            ST_REQ:  if (ack_i)              st_d = ST_XFER;  // grant
            ST_XFER: if (ack_i && xfer_last) st_d = ST_IDLE;  // done
            default:                         st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // shared address counter: sample index in capture, {channel, index} in transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: cnt_q <= '0;
                ST_CAPT: cnt_q <= cap_last ? '0 : cnt_q + 1'b1;
                ST_REQ:  cnt_q <= '0;
                ST_XFER: if (ack_i) cnt_q <= cnt_q + 1'b1;
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_o   = 1'b0;
        oe_o    = 1'b0;
        wr_en_o = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_CAPT: wr_en_o = 1'b1;
            ST_REQ:  req_o   = 1'b1;
            ST_XFER: oe_o    = 1'b1;
            default: ;
        endcase
    end

    assign cnt_o = cnt_q;

    a_r1_req_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_o && oe_o));

    a_r3_req_after_last_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> ($past(wr_en_o) && $past(cnt_q[IX_W-1:0]) == {IX_W{1'b1}}));

    a_r8_hold_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && !ack_i) |=> (oe_o && $stable(cnt_q)));

    a_r10_trig_ignored_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && trig_i && !ack_i) |=> req_o);

    a_r10_trig_ignored_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && trig_i) |=> !wr_en_o);

    a_r9_oe_falls_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_o) |-> ($past(ack_i) && $past(cnt_q) == {CNT_W{1'b1}}));
endmodule

// File: rtl/wcap_readout.sv
module wcap_readout
    import wcap_pkg::*;
#(
    parameter int NCH   = NCH_DEF,
    parameter int DW    = DW_DEF,
    parameter int DEPTH = DEPTH_DEF,
    localparam int CH_W   = $clog2(NCH),
    localparam int IX_W   = $clog2(DEPTH),
    localparam int CNT_W  = CH_W + IX_W,
    localparam int WORD_W = 2 + CH_W + IX_W + DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic [NCH*DW-1:0] adc_data,
    input  logic [NCH-1:0]    adc_ovr,
    output logic              host_req,
    input  logic              host_ack,
    output logic              bus_oe,
    inout  wire [WORD_W-1:0]  host_bus
);
    logic             wr_en;
    logic [CNT_W-1:0] cnt;
    logic [CH_W-1:0]  rd_ch;
    logic [IX_W-1:0]  idx;
    logic [DW:0]      bank_rd [NCH];
    logic [DW:0]      sel_rd;
    logic [WORD_W-1:0] word_w;

    wcap_seq #(
        .CH_W (CH_W),
        .IX_W (IX_W)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (trig_in),
        .ack_i   (host_ack),
        .req_o   (host_req),
        .oe_o    (bus_oe),
        .wr_en_o (wr_en),
        .cnt_o   (cnt)
    );

    assign idx   = cnt[IX_W-1:0];
    assign rd_ch = cnt[CNT_W-1:IX_W];

    for (genvar c = 0; c < NCH; c++) begin : g_bank
        wcap_bank #(
            .DW    (DW),
            .DEPTH (DEPTH)
        ) i_bank (
            .clk   (clk),
            .we    (wr_en),
            .waddr (idx),
            .wdata ({adc_ovr[c], adc_data[c*DW +: DW]}),
            .raddr (idx),
            .rdata (bank_rd[c])
        );
    end

    assign sel_rd = bank_rd[rd_ch];

    wcap_pack #(
        .DW   (DW),
        .CH_W (CH_W),
        .IX_W (IX_W)
    ) i_pack (
        .ovr  (sel_rd[DW]),
        .ch   (rd_ch),
        .idx  (idx),
        .data (sel_rd[DW-1:0]),
        .word (word_w)
    );

    assign host_bus = bus_oe ? word_w : {WORD_W{1'bz}};

    a_r6_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> ((^word_w) == 1'b0));
endmodule

// File: tb/test_wcap_readout.sv
module test_wcap_readout;
    localparam int NCH = 8;
    localparam int DW  = 10;
    localparam int DEP = 1024;
    localparam int NW  = NCH * DEP;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_in = 1'b0;
    logic [NCH*DW-1:0] adc_data = '0;
    logic [NCH-1:0]    adc_ovr = '0;
    logic              host_ack = 1'b0;
    logic              host_req;
    logic              bus_oe;
    wire  [24:0]       host_bus;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wcap_readout i_wcap_readout (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .adc_data (adc_data),
        .adc_ovr  (adc_ovr),
        .host_req (host_req),
        .host_ack (host_ack),
        .bus_oe   (bus_oe),
        .host_bus (host_bus)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] smp(input int ch, input int j, input int seed);
        return 10'((j * 7 + ch * 131 + seed * 37) & 1023);
    endfunction

    function automatic logic ovf(input int ch, input int j, input int seed);
        return ((j + 3 * ch + seed) % 13) == 0;
    endfunction

    function automatic logic [24:0] exp_word(input int k, input int seed);
        int ch = k / DEP;
        int j  = k % DEP;
        logic [23:0] b;
        b = {ovf(ch, j, seed), 3'(ch), 10'(j), smp(ch, j, seed)};
        return {^b, b};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk(host_req == 1'b0, "R1 req after reset", 32'(host_req), 0);
        chk(bus_oe == 1'b0, "R1 oe after reset", 32'(bus_oe), 0);
    endtask

    // drive trigger, then 1024 samples; optionally re-trigger mid-capture
    task automatic t_capture(input int seed, input bit retrig);
        @(negedge clk);
        trig_in = 1'b1;
        for (int j = 0; j < DEP; j++) begin
            @(negedge clk);
            trig_in = (retrig && (j == 500 || j == 501));   // R10 injection
            for (int c = 0; c < NCH; c++) begin
                adc_data[c*DW +: DW] = smp(c, j, seed);
                adc_ovr[c]           = ovf(c, j, seed);
            end
            if (j == DEP - 1)
                chk(host_req == 1'b0, "R3 req low before last write", 32'(host_req), 0);
        end
        @(negedge clk);
        trig_in  = 1'b0;
        adc_data = '1;
        adc_ovr  = '1;
        chk(host_req == 1'b1, "R3 req high after last write", 32'(host_req), 1);
        chk(bus_oe == 1'b0, "R3 oe low while requesting", 32'(bus_oe), 0);
    endtask

    // request phase with a trigger, then grant and stream all words
    task automatic t_transfer(input int seed, input bit gaps);
        int k = 0;
        int cyc = 0;
        logic [24:0] prev = '0;
        bit prev_ack = 1'b1;
        trig_in = 1'b1;                    // R10: trigger while requesting
        @(negedge clk);
        @(negedge clk);
        trig_in = 1'b0;
        chk(host_req == 1'b1, "R10 req held despite trigger", 32'(host_req), 1);
        chk(bus_oe == 1'b0, "R10 no transfer without accept", 32'(bus_oe), 0);
        host_ack = 1'b1;
        @(negedge clk);
        chk(host_req == 1'b0, "R4 req cleared on grant", 32'(host_req), 0);
        chk(bus_oe == 1'b1, "R4 oe set on grant", 32'(bus_oe), 1);
        while (k < NW) begin
            if (!prev_ack)
                chk(host_bus == prev, "R8 word held", 32'(host_bus), 32'(prev));
            chk(host_bus == exp_word(k, seed), "R5 R7 word content/order",
                32'(host_bus), 32'(exp_word(k, seed)));
            chk((^host_bus) == 1'b0, "R6 even parity", 32'(^host_bus), 0);
            chk(bus_oe == 1'b1, "R8 oe during transfer", 32'(bus_oe), 1);
            prev     = host_bus;
            prev_ack = gaps ? ((cyc % 5) != 3) : 1'b1;
            host_ack = prev_ack;
            trig_in  = (cyc % 97) == 11;   // R10: triggers during transfer
            cyc++;
            @(negedge clk);
            if (prev_ack) k++;
        end
        host_ack = 1'b0;
        trig_in  = 1'b0;
        chk(bus_oe == 1'b0, "R9 oe low after last word", 32'(bus_oe), 0);
        chk(host_req == 1'b0, "R9 req low after last word", 32'(host_req), 0);
        repeat (3) @(negedge clk);
        chk(bus_oe == 1'b0 && host_req == 1'b0, "R10 no capture from transfer trigger",
            32'({host_req, bus_oe}), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();                 // R1
        t_capture(1, 1'b1);        // R2 R3 R10
        t_transfer(1, 1'b1);       // R4..R10 with accept gaps
        t_capture(5, 1'b0);        // R11 fresh capture overwrites
        t_transfer(5, 1'b0);       // R11 full-rate readout of new data
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule